// File: doc/BRIEF.md
# Signal Quality Index Capture Unit

This block grades the link quality of each cable pair of a multi-pair line receiver. Every pair delivers an unsigned mean-square-error figure. The block compares that figure against a table of seven software-written ascending limits and produces a 3-bit index. Index 7 means the cleanest signal and index 0 the noisiest. A larger error crosses more limits and so yields a lower index.

Software reaches the block through a word-addressed register port. It writes a configuration word that turns grading on, picks a pair and raises a one-shot capture request. One cycle later the index of that pair is frozen in the status word. Each pair also keeps a running minimum of its index. The status word shows the minimum of the selected pair, and every read of the status word restarts that minimum from the index of that cycle.

Top module: `sqi_capture_unit`

## Requirements
- R1: While the enable bit (configuration bit 0) is 0, every pair's index is 0. A capture taken in that state stores 0 in the status current field.
- R2: With grading enabled, the index of a pair is 7 minus the number of limits T1..T7 that its error is strictly greater than. An error equal to a limit does not count as crossing it.
- R3: Writing address 0 with bit 1 set requests a capture of the pair named in bits 3:2 of the same word. On the clock after that write, the index of that pair is stored in status bits 2:0 (status is address 8).
- R4: The capture bit clears itself one clock after the write. A read of address 0 always returns bit 1 as 0.
- R5: Status bits 6:4 give the lowest index of the selected pair since the status word was last read. A status read reloads that pair's minimum with the pair's index in the read cycle.
- R6: While grading is disabled, the per-pair minimum holds its value except when a status read reloads it.
- R7: Address 0 reads back enable at bit 0 and the pair at bits 3:2. Addresses 1..7 read back limits T1..T7. Unmapped addresses read 0.
- R8: Reset clears enable, the pair selection, every limit and the status current field, and sets every per-pair minimum to 7.
- R9: The status current field holds its value until the next capture, whatever the error inputs do meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 8 restarts the minimum |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from the address |
| mse_i | input | NUM_CH x MSE_W | Per-pair error figures, pair 0 in the low slice |

## Verification
Each pair is given errors chosen to land a different number of limits below it: a clean value, a mid-table value, a value past every limit, and values exactly on and one above a limit. These tell an off-by-one or a wrong comparison direction apart from a correct map. A short error burst between two reads, followed by a second read, separates true running-minimum behaviour from a tracker that only follows the live value or is never restarted. Captures taken while disabled, and status reads taken without a new capture, separate enable gating and the held current field from a design that tracks the inputs directly.

// File: rtl/sqi_pkg.sv
package sqi_pkg;
   localparam int IDX_W   = 3;
   localparam int NUM_THR = (1 << IDX_W) - 1;
   localparam int ADDR_W  = 4;
   localparam logic [IDX_W-1:0] IDX_BEST = '1;

   localparam logic [ADDR_W-1:0] ADDR_CFG  = 4'd0;
   localparam logic [ADDR_W-1:0] ADDR_STAT = 4'd8;

   localparam int CFG_EN_BIT  = 0;
   localparam int CFG_CAP_BIT = 1;
   localparam int CFG_CH_LSB  = 2;
   localparam int STAT_WORST_LSB = 4;
endpackage

// File: rtl/sqi_regfile.sv
module sqi_regfile
   import sqi_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int MSE_W  = 16,
   parameter int DATA_W = 16,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_i,
   input  logic [ADDR_W-1:0]                 addr_i,
   input  logic [DATA_W-1:0]                 wdata_i,
   output logic                              en_o,
   output logic                              cap_o,
   output logic [CH_W-1:0]                   chan_o,
   output logic [NUM_THR-1:0][MSE_W-1:0]     thr_o
);
   logic cfg_hit;
   assign cfg_hit = wr_i && (addr_i == ADDR_CFG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= 1'b0;
         cap_o  <= 1'b0;
         chan_o <= '0;
      end else if (cfg_hit) begin
         en_o   <= wdata_i[CFG_EN_BIT];
         cap_o  <= wdata_i[CFG_CAP_BIT];
         chan_o <= wdata_i[CFG_CH_LSB +: CH_W];
      end else begin
         cap_o  <= 1'b0;
      end
   end

   for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
      logic [MSE_W-1:0] lim_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lim_q <= '0;
         else if (wr_i && (addr_i == ADDR_W'(t + 1)))
            lim_q <= wdata_i[MSE_W-1:0];
      end
      assign thr_o[t] = lim_q;
   end

   // R4: without a fresh request the capture pulse lasts one clock
   assert_capture_selfclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_o && !(wr_i && addr_i == ADDR_CFG && wdata_i[CFG_CAP_BIT]) |=> !cap_o);
endmodule

// File: rtl/sqi_threshold_map.sv
module sqi_threshold_map
   import sqi_pkg::*;
#(
   parameter int MSE_W = 16
) (
   input  logic                          en_i,
   input  logic [MSE_W-1:0]              mse_i,
   input  logic [NUM_THR-1:0][MSE_W-1:0] thr_i,
   output logic [IDX_W-1:0]              idx_o
);
   logic [IDX_W-1:0] crossed;

   always_comb begin
      crossed = '0;
      for (int t = 0; t < NUM_THR; t++)
         if (mse_i > thr_i[t]) crossed = crossed + 1'b1;
      idx_o = en_i ? (IDX_BEST - crossed) : '0;
   end
endmodule

// File: rtl/sqi_worst_tracker.sv
module sqi_worst_tracker
   import sqi_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             reload_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [IDX_W-1:0] worst_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         worst_o <= IDX_BEST;
      else if (reload_i)
         worst_o <= idx_i;
      else if (en_i && (idx_i < worst_o))
         worst_o <= idx_i;
   end

   // R6: frozen while disabled and not being read
   assert_worst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload_i && !en_i) |=> $stable(worst_o));
   // R5: never rises without a reload and never exceeds the index it saw
   assert_worst_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload_i && en_i) |=> (worst_o <= $past(worst_o)) && (worst_o <= $past(idx_i)));
endmodule

// File: rtl/sqi_capture_unit.sv
module sqi_capture_unit
   import sqi_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int MSE_W  = 16,
   parameter int DATA_W = 16,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_wr,
   input  logic                          reg_rd,
   input  logic [ADDR_W-1:0]             reg_addr,
   input  logic [DATA_W-1:0]             reg_wdata,
   output logic [DATA_W-1:0]             reg_rdata,
   input  logic [NUM_CH-1:0][MSE_W-1:0]  mse_i
);
   if (NUM_CH != 2 && NUM_CH != 4) begin : g_bad_ch
      $error("sqi_capture_unit: NUM_CH must be 2 or 4");
   end
   if (DATA_W < MSE_W || DATA_W < 8) begin : g_bad_dw
      $error("sqi_capture_unit: DATA_W too narrow");
   end

   logic                          en;
   logic                          cap;
   logic [CH_W-1:0]               chan;
   logic [NUM_THR-1:0][MSE_W-1:0] thr;
   logic [NUM_CH-1:0][IDX_W-1:0]  idx;
   logic [NUM_CH-1:0][IDX_W-1:0]  worst;
   logic [IDX_W-1:0]              stat_cur_q;
   logic                          stat_rd;

   sqi_regfile #(.NUM_CH(NUM_CH), .MSE_W(MSE_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .en_o(en), .cap_o(cap), .chan_o(chan), .thr_o(thr)
   );

   assign stat_rd = reg_rd && (reg_addr == ADDR_STAT);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      sqi_threshold_map #(.MSE_W(MSE_W)) u_map (
         .en_i(en), .mse_i(mse_i[c]), .thr_i(thr), .idx_o(idx[c])
      );
      sqi_worst_tracker u_worst (
         .clk(clk), .rst_n(rst_n), .en_i(en),
         .reload_i(stat_rd && (chan == CH_W'(c))),
         .idx_i(idx[c]), .worst_o(worst[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat_cur_q <= '0;
      else if (cap)
         stat_cur_q <= idx[chan];
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_CFG) begin
         reg_rdata[CFG_EN_BIT]            = en;
         reg_rdata[CFG_CH_LSB +: CH_W]    = chan;
      end else if (reg_addr == ADDR_STAT) begin
         reg_rdata[IDX_W-1:0]             = stat_cur_q;
         reg_rdata[STAT_WORST_LSB +: IDX_W] = worst[chan];
      end else begin
         for (int t = 0; t < NUM_THR; t++)
            if (reg_addr == ADDR_W'(t + 1)) reg_rdata[MSE_W-1:0] = thr[t];
      end
   end

   // R1: grading off forces every index to 0
   assert_idx_zero_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (idx == '0));
   // R3: a capture pulse freezes the selected pair's index
   assert_capture_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> stat_cur_q == $past(idx[chan]));
   // R9: status current field only moves on a capture
   assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(stat_cur_q));
   // R4: capture bit never visible on readback
   assert_cap_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_CFG) |-> !reg_rdata[CFG_CAP_BIT]);
endmodule

// File: tb/test_sqi_capture_unit.sv
`timescale 1ns/1ps
module test_sqi_capture_unit;
   localparam int NUM_CH = 4;
   localparam int MSE_W  = 16;
   localparam int DATA_W = 16;

   logic                         clk = 1'b0;
   logic                         rst_n = 1'b0;
   logic                         reg_wr = 1'b0;
   logic                         reg_rd = 1'b0;
   logic [3:0]                   reg_addr = '0;
   logic [DATA_W-1:0]            reg_wdata = '0;
   logic [DATA_W-1:0]            reg_rdata;
   logic [NUM_CH-1:0][MSE_W-1:0] mse = '0;

   int n_checks = 0;
   int n_fail   = 0;
   logic [DATA_W-1:0] exp_q[$];
   string             tag_q[$];
   bit                done = 1'b0;

   always #2 clk = ~clk;

   sqi_capture_unit #(.NUM_CH(NUM_CH), .MSE_W(MSE_W), .DATA_W(DATA_W)) i_sqi_capture_unit (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mse_i(mse)
   );

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] a, input logic [DATA_W-1:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // monitor: scoreboard pop and compare while a read is on the port
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (reg_rd) begin
            logic [DATA_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (reg_rdata !== e) begin
               n_fail++;
               $display("FAIL %s: addr %0d read 0x%0h expected 0x%0h", t, reg_addr, reg_rdata, e);
            end
         end
      end
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: timeout actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R8 reset state
      rd_reg(4'd0, 16'h0000, "R8 cfg after reset");
      rd_reg(4'd1, 16'h0000, "R8 T1 after reset");
      rd_reg(4'd8, 16'h0070, "R8 status after reset, worst 7"); // reloads pair0 with 0
      // program T1..T7 = 100..700
      for (int t = 1; t <= 7; t++) wr_reg(4'(t), 16'(t * 100));
      rd_reg(4'd3, 16'd300, "R7 T3 readback");
      rd_reg(4'd7, 16'd700, "R7 T7 readback");
      rd_reg(4'd9, 16'h0000, "R7 unmapped address");
      mse[0] = 16'd50; mse[1] = 16'd250; mse[2] = 16'd1000; mse[3] = 16'd700;
      // enable, capture pair1 (bits: en=0, cap=1, chan=3:2)
      wr_reg(4'd0, 16'h0007);
      idle(1);
      rd_reg(4'd0, 16'h0005, "R4 R7 cfg readback, capture bit 0");
      rd_reg(4'd8, 16'h0055, "R2 R3 pair1 mid-table index 5");
      // pair3 error equals T7 -> index 1
      wr_reg(4'd0, 16'h000F);
      idle(1);
      rd_reg(4'd8, 16'h0011, "R2 pair3 equal to T7 gives 1");
      // error burst on pair3 then recovery
      mse[3] = 16'd1000; idle(3); mse[3] = 16'd700; idle(2);
      wr_reg(4'd0, 16'h000F);
      idle(1);
      rd_reg(4'd8, 16'h0001, "R5 pair3 worst keeps burst minimum 0");
      wr_reg(4'd0, 16'h000F);
      idle(1);
      rd_reg(4'd8, 16'h0011, "R5 pair3 worst restarted by read");
      // R9: no capture, pair3 improves, current field holds
      mse[3] = 16'd50; idle(3);
      rd_reg(4'd8, 16'h0011, "R9 current field held without capture");
      // pair0 clean: worst still 0 from reload while disabled
      wr_reg(4'd0, 16'h0003);
      idle(1);
      rd_reg(4'd8, 16'h0007, "R2 R5 pair0 index 7 worst 0");
      rd_reg(4'd8, 16'h0077, "R5 pair0 worst after restart");
      // pair2 boundary: on T1 and one above
      mse[2] = 16'd100; idle(2);
      wr_reg(4'd0, 16'h000B);
      idle(1);
      rd_reg(4'd8, 16'h0007, "R2 pair2 on T1 gives 7, worst 0 from earlier");
      mse[2] = 16'd101; idle(2);
      wr_reg(4'd0, 16'h000B);
      idle(1);
      rd_reg(4'd8, 16'h0066, "R2 pair2 one above T1 gives 6");
      // disable with capture on pair2
      wr_reg(4'd0, 16'h000A);
      idle(2);
      rd_reg(4'd8, 16'h0060, "R1 R6 disabled capture 0, worst held 6");
      rd_reg(4'd0, 16'h0008, "R4 R7 cfg readback when disabled");
      idle(4);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule